// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit decides, for one control-transfer or conditional-set instruction, whether the condition it names holds. It also forms the address that a jump would reach. The execute stage presents four flags (equal, sign, zero, overflow) together with a condition selector. It also supplies the address of the instruction after the branch and an offset. The offset is either a 16-bit immediate taken from the instruction or a 32-bit register value. The unit returns a taken decision, a 32-bit target, and a 32-bit value of 0 or 1 that a conditional-set instruction writes to its destination register.

The unit has one register stage. A request is presented with `req_valid` high. Its results appear with `rsp_valid` high on the following cycle, and they stay on the outputs until the next request arrives. The target is always relative: the register form of the operand is an offset, not an absolute address. Both operand forms are added to the already-advanced PC. The target is formed even when the branch is not taken. Pushing a stack frame for calls is left to other logic.

There is no state machine. The block holds a single result register, and it moves between two named conditions. In IDLE, `rsp_valid` is low and the held result is kept. In RESULT, `rsp_valid` is high for one cycle. The transition IDLE→RESULT or RESULT→RESULT happens when `req_valid` is high. The transition RESULT→IDLE or IDLE→IDLE happens when `req_valid` is low. Reset forces IDLE with a zero result.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `rsp_valid` and `rsp_taken` are 0, and `rsp_target` and `rsp_setval` are 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` is high. The results of that request are on the outputs in that same cycle.
- R3: In a cycle where `req_valid` is low, the outputs `rsp_taken`, `rsp_target` and `rsp_setval` keep their previous values, whatever the other inputs do.
- R4: With `use_imm` = 0, `rsp_target` equals `next_pc + reg_off` modulo 2^32. `imm_off` has no effect in this case.
- R5: With `use_imm` = 1, `rsp_target` equals `next_pc` plus `imm_off` sign-extended from 16 to 32 bits, modulo 2^32. `reg_off` has no effect in this case.
- R6: Single-flag codes decide as follows. 1 = taken when e=1, 2 = when e=0, 3 = when s=1, 4 = when s=0, 5 = when z=1, 6 = when z=0, 7 = when o=1, 8 = when o=0. No other flag affects these codes.
- R7: Compound codes decide as follows. 9 (greater) = taken when e=0 and s=0. 10 (greater-or-equal) = taken when e=1 or s=0. 11 (less) = taken when e=0 and s=1. 12 (less-or-equal) = taken when e=1 or s=1.
- R8: Code 0 (always) is taken for every combination of flags.
- R9: Codes 13 to 31 are reserved and are never taken.
- R10: `rsp_setval` equals `rsp_taken` zero-extended to 32 bits, so it is 1 when the condition holds and 0 when it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| cond_sel | input | 5 | Condition selector (see R6–R9) |
| flag_e | input | 1 | Equal flag |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_o | input | 1 | Overflow flag |
| next_pc | input | 32 | Address of the instruction after the branch |
| use_imm | input | 1 | 1 selects the immediate offset, 0 selects the register offset |
| imm_off | input | 16 | Immediate offset, sign-extended |
| reg_off | input | 32 | Register offset |
| rsp_valid | output | 1 | Results of the previous cycle's request are present |
| rsp_taken | output | 1 | The condition held |
| rsp_target | output | 32 | Computed jump address |
| rsp_setval | output | 32 | 0 or 1 value for a conditional-set destination |

## Verification
The assertions assume that the flag, selector and operand inputs carry known 0/1 values in every cycle where `req_valid` is high. They also assume that `req_valid` is low while reset is applied. The bench meets both conditions by driving every input to a defined value from time zero. It changes inputs only on the falling edge and holds `req_valid` low around each reset. When the bench checks the hold behaviour, it scrambles the other inputs only in cycles where `req_valid` is low, so the hold assertion sees the situation it guards.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int SEL_W = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALWAYS = 5'd0,
        SEL_EQ     = 5'd1,
        SEL_NE     = 5'd2,
        SEL_NEG    = 5'd3,
        SEL_NNEG   = 5'd4,
        SEL_ZERO   = 5'd5,
        SEL_NZERO  = 5'd6,
        SEL_OVF    = 5'd7,
        SEL_NOVF   = 5'd8,
        SEL_GT     = 5'd9,
        SEL_GE     = 5'd10,
        SEL_LT     = 5'd11,
        SEL_LE     = 5'd12
    } cond_sel_e;

    localparam logic [SEL_W-1:0] SEL_LAST_VALID = 5'd12;

endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             fe,
    input  logic             fs,
    input  logic             fz,
    input  logic             fo,
    output logic             hit
);

    always_comb begin
        case (sel)
            SEL_ALWAYS: hit = 1'b1;
            SEL_EQ:     hit = fe;
            SEL_NE:     hit = !fe;
            SEL_NEG:    hit = fs;
            SEL_NNEG:   hit = !fs;
            SEL_ZERO:   hit = fz;
            SEL_NZERO:  hit = !fz;
            SEL_OVF:    hit = fo;
            SEL_NOVF:   hit = !fo;
            SEL_GT:     hit = !fe && !fs;
            SEL_GE:     hit = fe || !fs;
            SEL_LT:     hit = !fe && fs;
            SEL_LE:     hit = fe || fs;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcu_target_add.sv
module bcu_target_add #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              pick_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] roff,
    output logic [ADDR_W-1:0] dest
);

    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_sext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[ADDR_W-1:0];
        end
    endgenerate

    assign dest = base + (pick_imm ? imm_ext : roff);

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        cond_sel,
    input  logic              flag_e,
    input  logic              flag_s,
    input  logic              flag_z,
    input  logic              flag_o,
    input  logic [31:0]       next_pc,
    input  logic              use_imm,
    input  logic [15:0]       imm_off,
    input  logic [31:0]       reg_off,
    output logic              rsp_valid,
    output logic              rsp_taken,
    output logic [31:0]       rsp_target,
    output logic [31:0]       rsp_setval
);

    logic              hit_c;
    logic [ADDR_W-1:0] dest_c;

    bcu_cond_eval u_eval (
        .sel (cond_sel),
        .fe  (flag_e),
        .fs  (flag_s),
        .fz  (flag_z),
        .fo  (flag_o),
        .hit (hit_c)
    );

    bcu_target_add #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_add (
        .base     (next_pc),
        .pick_imm (use_imm),
        .imm      (imm_off),
        .roff     (reg_off),
        .dest     (dest_c)
    );

    // Result register: IDLE when rsp_valid low, RESULT when high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_taken  <= 1'b0;
            rsp_target <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_taken  <= hit_c;
                rsp_target <= dest_c;
            end
        end
    end

    always_comb begin
        rsp_setval    = '0;
        rsp_setval[0] = rsp_taken;
    end

    // R2: response follows a request by exactly one cycle
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: outputs hold between requests
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_taken) && $stable(rsp_target)));

    // R5: zero immediate lands on the advanced PC
    a_r5_zero_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && use_imm && imm_off == '0) |=> rsp_target == $past(next_pc));

    // R8: the always code is taken
    a_r8_always: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_sel == SEL_ALWAYS) |=> rsp_taken);

    // R9: reserved codes never taken
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cond_sel > SEL_LAST_VALID) |=> !rsp_taken);

    // R7: greater and less exclude equality
    a_r7_strict: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flag_e && (cond_sel == SEL_GT || cond_sel == SEL_LT)) |=> !rsp_taken);

    // R10: set value is 0 or 1
    a_r10_setval: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rsp_setval) <= 1);

endmodule

// File: tb/sim_branch_cond_unit.sv
module sim_branch_cond_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  cond_sel = '0;
    logic        flag_e = 1'b0, flag_s = 1'b0, flag_z = 1'b0, flag_o = 1'b0;
    logic [31:0] next_pc = '0;
    logic        use_imm = 1'b0;
    logic [15:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic        rsp_valid, rsp_taken;
    logic [31:0] rsp_target, rsp_setval;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    branch_cond_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cond_sel(cond_sel),
        .flag_e(flag_e), .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o),
        .next_pc(next_pc), .use_imm(use_imm), .imm_off(imm_off), .reg_off(reg_off),
        .rsp_valid(rsp_valid), .rsp_taken(rsp_taken),
        .rsp_target(rsp_target), .rsp_setval(rsp_setval)
    );

    // {code[4:0], e, s, z, o, expected_taken}
    localparam int NV = 29;
    localparam logic [9:0] VEC [NV] = '{
        {5'd1,  4'b1000, 1'b1}, {5'd1,  4'b0111, 1'b0},
        {5'd2,  4'b0000, 1'b1}, {5'd2,  4'b1000, 1'b0},
        {5'd3,  4'b0100, 1'b1}, {5'd4,  4'b0100, 1'b0},
        {5'd5,  4'b0010, 1'b1}, {5'd5,  4'b1101, 1'b0},
        {5'd6,  4'b0010, 1'b0}, {5'd6,  4'b0000, 1'b1},
        {5'd7,  4'b0001, 1'b1}, {5'd8,  4'b0001, 1'b0},
        {5'd8,  4'b1110, 1'b1},
        {5'd9,  4'b0000, 1'b1}, {5'd9,  4'b0100, 1'b0}, {5'd9,  4'b1000, 1'b0},
        {5'd10, 4'b1100, 1'b1}, {5'd10, 4'b0100, 1'b0}, {5'd10, 4'b0000, 1'b1},
        {5'd11, 4'b0100, 1'b1}, {5'd11, 4'b1100, 1'b0}, {5'd11, 4'b0000, 1'b0},
        {5'd12, 4'b0000, 1'b0}, {5'd12, 4'b1000, 1'b1}, {5'd12, 4'b0100, 1'b1},
        {5'd0,  4'b0000, 1'b1}, {5'd0,  4'b1111, 1'b1},
        {5'd13, 4'b1111, 1'b0}, {5'd31, 4'b1111, 1'b0}
    };

    function automatic string tag_of(input logic [4:0] c);
        if (c == 5'd0) return "R8";
        if (c <= 5'd8) return "R6";
        if (c <= 5'd12) return "R7";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one request at a falling edge; results are checked at the next falling edge
    task automatic issue(input logic [4:0] c, input logic [3:0] f, input logic [31:0] pc,
                         input logic ui, input logic [15:0] im, input logic [31:0] ro);
        @(negedge clk);
        req_valid = 1'b1; cond_sel = c;
        {flag_e, flag_s, flag_z, flag_o} = f;
        next_pc = pc; use_imm = ui; imm_off = im; reg_off = ro;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 taken", {31'd0, rsp_taken}, 32'd0);
        check("R1 target", rsp_target, 32'd0);
        check("R1 setval", rsp_setval, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, rsp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][9:5], VEC[i][4:1], 32'h100 + i, 1'b0, 16'h0, 32'h4);
            check({tag_of(VEC[i][9:5]), " taken"}, {31'd0, rsp_taken}, {31'd0, VEC[i][0]});
            check("R10 setval", rsp_setval, {31'd0, VEC[i][0]});
            check("R2 valid", {31'd0, rsp_valid}, 32'd1);
        end

        // R4: register offset, immediate ignored
        issue(5'd0, 4'b0000, 32'h0000_1000, 1'b0, 16'h8000, 32'h10);
        check("R4 reg offset", rsp_target, 32'h0000_1010);
        issue(5'd9, 4'b1000, 32'hFFFF_FFF0, 1'b0, 16'h1234, 32'h20);
        check("R4 wrap not-taken", rsp_target, 32'h0000_0010);
        check("R7 not taken with target", {31'd0, rsp_taken}, 32'd0);
        issue(5'd0, 4'b0000, 32'h0000_2000, 1'b0, 16'h0, 32'hFFFF_FFF8);
        check("R4 negative reg", rsp_target, 32'h0000_1FF8);
        // R5: immediate sign extension, register ignored
        issue(5'd0, 4'b0000, 32'h0000_1000, 1'b1, 16'hFFFC, 32'h55);
        check("R5 negative imm", rsp_target, 32'h0000_0FFC);
        issue(5'd0, 4'b0000, 32'h0000_1000, 1'b1, 16'h7FFF, 32'hAAAA_AAAA);
        check("R5 max imm", rsp_target, 32'h0000_8FFF);
        issue(5'd0, 4'b0000, 32'h0001_0000, 1'b1, 16'h8000, 32'h0);
        check("R5 min imm", rsp_target, 32'h0000_8000);

        // R3: hold while idle, with scrambled inputs
        issue(5'd5, 4'b0010, 32'h0000_4000, 1'b1, 16'h0040, 32'h0);
        check("R2 valid", {31'd0, rsp_valid}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            cond_sel = 5'd6; {flag_e, flag_s, flag_z, flag_o} = 4'b0000;
            next_pc = 32'hDEAD_0000 + k; use_imm = 1'b0; reg_off = 32'h99;
            @(negedge clk);
            check("R3 taken held", {31'd0, rsp_taken}, 32'd1);
            check("R3 target held", rsp_target, 32'h0000_4040);
            check("R2 valid low", {31'd0, rsp_valid}, 32'd0);
        end

        // R1: mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset taken", {31'd0, rsp_taken}, 32'd0);
        check("R1 re-reset target", rsp_target, 32'd0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule